// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Match Alarm

This block keeps wall-clock time for a chip that has a slow 32768 Hz timebase. It holds six packed-BCD bytes (year within the 2000 to 2099 century, month, day of month, hour in 24-hour form, minute, second) and advances them by one second after a parameterised number of tick pulses. The tick arrives as a one-cycle enable on the fabric clock. A prescaler counts ticks only while the run input is high. The calendar carry chain wraps each field at its own limit. The day limit follows the current month, and February gains a 29th day in years divisible by four.

Software sets the time and the alarm from a shared 48-bit load bus. A time load restarts the prescaler, so the first second after a load is a full one. The alarm compares all six fields and has no wildcards. A full match sets a sticky flag, which software clears by writing a one. A one-cycle event marks each seconds increment and can be routed to a timer interrupt. A busy output covers the last tick interval before each increment. Software should hold off time accesses while it is high.

Top module: `rtcal_core`

## Requirements
- R1: After reset the time reads 48'h000101000000 and alarm_flag, busy, sec_evt and timer_irq are low. The bus layout is sec in [7:0], minute in [15:8], hour in [23:16], day in [31:24], month in [39:32] and year in [47:40].
- R2: Time advances by one second on the TICKS_PER_SEC-th cycle that has both tick and run high. Cycles without tick, and all cycles with run low, leave the time unchanged.
- R3: A load_time pulse writes all six fields from load_value together and clears the prescaler, so the next increment needs a full TICKS_PER_SEC ticks. A load in the same cycle as an increment takes priority, and no sec_evt is produced.
- R4: Seconds and minutes wrap from 59 to 00 and hours from 23 to 00, each carrying into the next field.
- R5: Day wraps to 01 after the last day of the current month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year value is divisible by 4 (including 00) and 28 otherwise. Month 12 wraps to 01, and year 99 wraps to 00.
- R6: Loaded values with illegal BCD are kept as written. On increment, a field whose low nibble is 9 or more moves to the next tens value with a low nibble of 0. A field at or above its maximum wraps to its minimum and carries.
- R7: alarm_flag is set when an increment produces a time equal to the stored alarm in all six fields. A difference in any single field prevents it.
- R8: alarm_flag stays set until alarm_clr is high for a cycle. A new match in the same cycle as a clear leaves the flag set.
- R9: sec_evt is high for the one cycle after each increment. timer_irq is high in that same cycle if tmr_ie was high, and alarm_irq equals alarm_flag AND alm_ie.
- R10: busy is high exactly while run is high and the prescaler is in its final tick interval before an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32768 Hz timebase enable |
| run | input | 1 | Time advances while high |
| load_time | input | 1 | Write load_value into the time fields |
| load_alarm | input | 1 | Write load_value into the alarm fields |
| load_value | input | 48 | Packed BCD {year, month, day, hour, minute, second} |
| alarm_clr | input | 1 | Write-one clear of alarm_flag |
| tmr_ie | input | 1 | Enables the timer interrupt |
| alm_ie | input | 1 | Enables the alarm interrupt |
| time_now | output | 48 | Current packed BCD time |
| busy | output | 1 | Final tick interval before an increment |
| sec_evt | output | 1 | One-cycle pulse after each increment |
| timer_irq | output | 1 | sec_evt gated by tmr_ie |
| alarm_irq | output | 1 | alarm_flag gated by alm_ie |
| alarm_flag | output | 1 | Sticky full-match alarm status |

## Verification
The bench targets the calendar edges:
- the century rollover from 99-12-31 23:59:59;
- February 28 in leap and non-leap years, including year 00;
- the 30-day months and a 31-day month.

A wrong month-length decode shows up as a skipped or doubled day. The bench drives illegal BCD such as 4A, 5F, 7C and hour 2F; a naive incrementer would step these to further illegal codes instead of wrapping. Prescaler restart is checked with a second load mid-count, and a design that did not restart would increment early. The alarm is checked against a one-field mismatch, for stickiness, and with a clear that collides with a match; a wrong priority would drop the flag.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

  localparam int NFIELD = 6;
  localparam int FW     = 8;

  typedef struct packed {
    logic [FW-1:0] yr;
    logic [FW-1:0] mon;
    logic [FW-1:0] day;
    logic [FW-1:0] hr;
    logic [FW-1:0] mn;
    logic [FW-1:0] sec;
  } stamp_t;

  localparam stamp_t RESET_STAMP = '{yr: 8'h00, mon: 8'h01, day: 8'h01,
                                     hr: 8'h00, mn: 8'h00, sec: 8'h00};

  // Last legal day (BCD) of the given month in the given year.
  function automatic logic [FW-1:0] last_day(input logic [FW-1:0] mon,
                                             input logic [FW-1:0] yr);
    logic [7:0] yr_bin;
    logic       leap;
    yr_bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    leap   = (yr_bin[1:0] == 2'b00);
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcal_bcd_step.sv
module rtcal_bcd_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] lo_lim,
  input  logic [W-1:0] hi_lim,
  input  logic         inc,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (inc) begin
      if (cur >= hi_lim) begin
        nxt  = lo_lim;
        wrap = 1'b1;
      end else if (cur[3:0] >= 4'd9) begin
        nxt = {cur[W-1:4] + 1'b1, 4'd0};
      end else begin
        nxt = {cur[W-1:4], cur[3:0] + 4'd1};
      end
    end
  end
endmodule

// File: rtl/rtcal_calendar.sv
module rtcal_calendar
  import rtcal_pkg::*;
(
  input  stamp_t cur,
  output stamp_t nxt
);
  logic [FW-1:0] cur_f [NFIELD];
  logic [FW-1:0] lo_f  [NFIELD];
  logic [FW-1:0] hi_f  [NFIELD];
  logic [FW-1:0] nxt_f [NFIELD];
  logic [NFIELD:0] carry;

  assign carry[0] = 1'b1;

  assign cur_f[0] = cur.sec;  assign lo_f[0] = 8'h00; assign hi_f[0] = 8'h59;
  assign cur_f[1] = cur.mn;   assign lo_f[1] = 8'h00; assign hi_f[1] = 8'h59;
  assign cur_f[2] = cur.hr;   assign lo_f[2] = 8'h00; assign hi_f[2] = 8'h23;
  assign cur_f[3] = cur.day;  assign lo_f[3] = 8'h01; assign hi_f[3] = last_day(cur.mon, cur.yr);
  assign cur_f[4] = cur.mon;  assign lo_f[4] = 8'h01; assign hi_f[4] = 8'h12;
  assign cur_f[5] = cur.yr;   assign lo_f[5] = 8'h00; assign hi_f[5] = 8'h99;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    rtcal_bcd_step #(.W(FW)) u_step (
      .cur    (cur_f[i]),
      .lo_lim (lo_f[i]),
      .hi_lim (hi_f[i]),
      .inc    (carry[i]),
      .nxt    (nxt_f[i]),
      .wrap   (carry[i+1])
    );
  end

  assign nxt = '{yr: nxt_f[5], mon: nxt_f[4], day: nxt_f[3],
                 hr: nxt_f[2], mn: nxt_f[1], sec: nxt_f[0]};
endmodule

// File: rtl/rtcal_prescaler.sv
module rtcal_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic upd,
  output logic busy
);
  localparam int CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam int LAST = TICKS - 1;

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == CW'(LAST));
  assign upd     = run && tick && at_last;
  assign busy    = run && at_last;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= at_last ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rtcal_alarm.sv
module rtcal_alarm
  import rtcal_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_alarm,
  input  stamp_t load_value,
  input  logic   step,
  input  stamp_t next_time,
  input  logic   clr,
  output logic   flag
);
  stamp_t target;
  logic   hit;

  assign hit = step && (next_time == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      target <= '0;
      flag   <= 1'b0;
    end else begin
      if (load_alarm) target <= load_value;
      if (hit)        flag   <= 1'b1;
      else if (clr)   flag   <= 1'b0;
    end
  end
endmodule

// File: rtl/rtcal_core.sv
module rtcal_core
  import rtcal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        run,
  input  logic        load_time,
  input  logic        load_alarm,
  input  logic [47:0] load_value,
  input  logic        alarm_clr,
  input  logic        tmr_ie,
  input  logic        alm_ie,
  output logic [47:0] time_now,
  output logic        busy,
  output logic        sec_evt,
  output logic        timer_irq,
  output logic        alarm_irq,
  output logic        alarm_flag
);
  stamp_t now_q, now_nxt;
  logic   upd, step;

  rtcal_prescaler #(.TICKS(TICKS_PER_SEC)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (run),
    .restart (load_time),
    .upd     (upd),
    .busy    (busy)
  );

  rtcal_calendar u_cal (
    .cur (now_q),
    .nxt (now_nxt)
  );

  assign step = upd && !load_time;

  rtcal_alarm u_alm (
    .clk        (clk),
    .rst        (rst),
    .load_alarm (load_alarm),
    .load_value (stamp_t'(load_value)),
    .step       (step),
    .next_time  (now_nxt),
    .clr        (alarm_clr),
    .flag       (alarm_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q     <= RESET_STAMP;
      sec_evt   <= 1'b0;
      timer_irq <= 1'b0;
    end else begin
      if (load_time) now_q <= stamp_t'(load_value);
      else if (step) now_q <= now_nxt;
      sec_evt   <= step;
      timer_irq <= step && tmr_ie;
    end
  end

  assign time_now  = now_q;
  assign alarm_irq = alarm_flag && alm_ie;
endmodule

// File: rtl/rtcal_core_chk.sv
module rtcal_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        run,
  input logic        load_time,
  input logic        alarm_clr,
  input logic        tmr_ie,
  input logic [47:0] time_now,
  input logic        busy,
  input logic        sec_evt,
  input logic        timer_irq,
  input logic        alarm_flag
);
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_time && !(run && tick)) |=> $stable(time_now));

  assert_evt_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
    sec_evt |-> $past(run && tick));

  assert_sec_legal_R4: assert property (@(posedge clk) disable iff (rst)
    sec_evt |-> (time_now[7:4] <= 4'd5 && time_now[3:0] <= 4'd9));

  assert_flag_rise_on_step_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> sec_evt);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && alarm_clr && !(run && tick)) |=> !alarm_flag);

  assert_timer_gate_R9: assert property (@(posedge clk) disable iff (rst)
    timer_irq |-> (sec_evt && $past(tmr_ie)));

  assert_busy_needs_run_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> run);

  assert_busy_before_step_R10: assert property (@(posedge clk) disable iff (rst)
    sec_evt |-> $past(busy));
endmodule

bind rtcal_core rtcal_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .run        (run),
  .load_time  (load_time),
  .alarm_clr  (alarm_clr),
  .tmr_ie     (tmr_ie),
  .time_now   (time_now),
  .busy       (busy),
  .sec_evt    (sec_evt),
  .timer_irq  (timer_irq),
  .alarm_flag (alarm_flag)
);

// File: tb/sim_rtcal_core.sv
module sim_rtcal_core;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1, run = 1'b0;
  logic        load_time = 1'b0, load_alarm = 1'b0;
  logic [47:0] load_value = '0;
  logic        alarm_clr = 1'b0, tmr_ie = 1'b0, alm_ie = 1'b0;
  logic [47:0] time_now;
  logic        busy, sec_evt, timer_irq, alarm_irq, alarm_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcal_core #(.TICKS_PER_SEC(DIV)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .load_time(load_time), .load_alarm(load_alarm), .load_value(load_value),
    .alarm_clr(alarm_clr), .tmr_ie(tmr_ie), .alm_ie(alm_ie),
    .time_now(time_now), .busy(busy), .sec_evt(sec_evt),
    .timer_irq(timer_irq), .alarm_irq(alarm_irq), .alarm_flag(alarm_flag)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called just after a negedge; leaves the prescaler at zero.
  task automatic load_t(input logic [47:0] v);
    load_time = 1'b1; load_value = v;
    @(negedge clk);
    load_time = 1'b0;
  endtask

  task automatic load_a(input logic [47:0] v);
    load_alarm = 1'b1; load_value = v;
    @(negedge clk);
    load_alarm = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 time", time_now, 48'h000101000000);
    chk("R1 flag", {47'd0, alarm_flag}, 48'd0);
    chk("R1 busy", {47'd0, busy}, 48'd0);
    chk("R1 evt", {47'd0, sec_evt | timer_irq}, 48'd0);
  endtask

  task automatic t_run_stop;
    run = 1'b0;
    load_t(48'h240315102030);
    cyc(20);
    chk("R2 stopped", time_now, 48'h240315102030);
    run = 1'b1;
    cyc(3);
    chk("R2 before", time_now, 48'h240315102030);
    chk("R10 busy high", {47'd0, busy}, 48'd1);
    cyc(1);
    chk("R2 advance", time_now, 48'h240315102031);
    chk("R10 busy low", {47'd0, busy}, 48'd0);
    chk("R9 evt", {47'd0, sec_evt}, 48'd1);
    chk("R9 timer off", {47'd0, timer_irq}, 48'd0);
    cyc(1);
    chk("R9 evt one cycle", {47'd0, sec_evt}, 48'd0);
    // gapped ticks: only tick cycles count
    load_t(48'h240315102030);
    for (int i = 0; i < 7; i++) begin
      tick = (i % 2 == 0);
      @(negedge clk);
    end
    chk("R2 gapped early", time_now, 48'h240315102031);
    tick = 1'b1;
    load_t(48'h240315102030);
    for (int i = 0; i < 6; i++) begin
      tick = (i % 2 == 0);
      @(negedge clk);
    end
    chk("R2 gapped hold", time_now, 48'h240315102030);
    tick = 1'b1;
  endtask

  task automatic t_load;
    load_t(48'h240315102010);
    cyc(2);
    load_t(48'h240315102040);
    cyc(2);
    chk("R3 restart", time_now, 48'h240315102040);
    cyc(1);
    chk("R3 full second", time_now, 48'h240315102040);
    cyc(1);
    chk("R3 then advance", time_now, 48'h240315102041);
    load_t(48'h240315102010);
    cyc(3);
    load_t(48'h240315102040);
    chk("R3 load wins", time_now, 48'h240315102040);
    chk("R3 no evt", {47'd0, sec_evt}, 48'd0);
  endtask

  task automatic wrap_case(input string req, input logic [47:0] from, input logic [47:0] to);
    load_t(from);
    cyc(DIV);
    chk(req, time_now, to);
  endtask

  task automatic t_wraps;
    wrap_case("R4 min carry",  48'h240315102059, 48'h240315102100);
    wrap_case("R4 hour carry", 48'h240315105959, 48'h240315110000);
    wrap_case("R4 day carry",  48'h240315235959, 48'h240316000000);
    wrap_case("R5 century",    48'h991231235959, 48'h000101000000);
    wrap_case("R5 leap 28",    48'h240228235959, 48'h240229000000);
    wrap_case("R5 leap 29",    48'h240229235959, 48'h240301000000);
    wrap_case("R5 plain feb",  48'h230228235959, 48'h230301000000);
    wrap_case("R5 year00",     48'h000228235959, 48'h000229000000);
    wrap_case("R5 april",      48'h240430235959, 48'h240501000000);
    wrap_case("R5 sept",       48'h240930235959, 48'h241001000000);
    wrap_case("R5 nov",        48'h241130235959, 48'h241201000000);
    wrap_case("R5 jan31",      48'h240131235959, 48'h240201000000);
    wrap_case("R5 jan30",      48'h240130235959, 48'h240131000000);
  endtask

  task automatic t_illegal;
    load_t(48'h24031510204A);
    chk("R6 kept", time_now, 48'h24031510204A);
    cyc(DIV);
    chk("R6 low nibble", time_now, 48'h240315102050);
    wrap_case("R6 5F",      48'h24031510205F, 48'h240315102100);
    wrap_case("R6 7C",      48'h24031510207C, 48'h240315102100);
    wrap_case("R6 hour 2F", 48'h2403152F5959, 48'h240316000000);
  endtask

  task automatic t_alarm;
    alm_ie = 1'b0;
    load_a(48'h240315102005);
    load_t(48'h240315102003);
    cyc(DIV);
    chk("R7 no early", {47'd0, alarm_flag}, 48'd0);
    cyc(DIV);
    chk("R7 match", {47'd0, alarm_flag}, 48'd1);
    chk("R9 alarm gated", {47'd0, alarm_irq}, 48'd0);
    alm_ie = 1'b1;
    #1;
    chk("R9 alarm irq", {47'd0, alarm_irq}, 48'd1);
    cyc(DIV);
    chk("R8 sticky", {47'd0, alarm_flag}, 48'd1);
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
    chk("R8 cleared", {47'd0, alarm_flag}, 48'd0);
    chk("R9 irq follows", {47'd0, alarm_irq}, 48'd0);
    // one field off: year
    load_a(48'h250315102005);
    load_t(48'h240315102003);
    cyc(2*DIV + 1);
    chk("R7 year differs", {47'd0, alarm_flag}, 48'd0);
    // one field off: month
    load_a(48'h240415102005);
    load_t(48'h240315102003);
    cyc(2*DIV + 1);
    chk("R7 month differs", {47'd0, alarm_flag}, 48'd0);
    // set beats clear in the same cycle
    load_a(48'h240315102005);
    load_t(48'h240315102004);
    cyc(DIV - 1);
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
    chk("R8 set wins", {47'd0, alarm_flag}, 48'd1);
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
    alm_ie = 1'b0;
  endtask

  task automatic t_timer;
    tmr_ie = 1'b1;
    load_t(48'h240315102000);
    cyc(DIV);
    chk("R9 timer irq", {47'd0, timer_irq}, 48'd1);
    cyc(1);
    chk("R9 timer pulse", {46'd0, timer_irq, sec_evt}, 48'd0);
    tmr_ie = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset;
    t_run_stop;
    t_load;
    t_wraps;
    t_illegal;
    t_alarm;
    t_timer;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule